// File: doc/BRIEF.md
# De Bruijn Route Digit Generator

This block works out a fixed-length source route through a generalized binary de Bruijn network of `N_NODES` switches whose route length is `DIAM` hops. Given a source switch index and a destination switch index, it produces the `DIAM`-bit route word T = (d − s·2^DIAM) mod `N_NODES`. It then streams the switches that route passes through, one per cycle, starting at the source and ending at the destination. `N_NODES` may be any natural number and need not be a power of two.

A switch or packet builder pulses `start` with the two indices. The block first folds s·2^DIAM into the range 0..N_NODES−1 by doubling it and subtracting the modulus when needed. It then takes the difference to the destination modulo `N_NODES` and walks the path. Each step is next = (2·current + digit) mod `N_NODES`, with the route digits taken from the most significant bit down. No multiplier and no divider is used. After the last node, a one-cycle `done` marks the route word as ready.

Top module: `dbj_route_gen`

## Requirements
- R1: After reset, `done` and `node_vld` are 0 and `route_word` is 0.
- R2: When `done` is high, `route_word` equals (dst − src·2^DIAM) mod N_NODES as an unsigned DIAM-bit number. It keeps that value until the next accepted start. For N_NODES=14, DIAM=4, src=3 and dst=10, it is 4 (binary 0100).
- R3: Each accepted start yields exactly DIAM+1 node outputs on consecutive cycles, with `node_idx` counting 0, 1, …, DIAM. The node at index 0 is the source.
- R4: The node at index k>0 equals (2·previous node + route_word bit [DIAM−k]) mod N_NODES, so the route bits are consumed most significant first. For N_NODES=14, src=3 and dst=10, the stream is 3, 6, 13, 12, 10.
- R5: The node at index DIAM equals the destination, and this also holds when source and destination are equal.
- R6: Every streamed node is below N_NODES, provided both inputs are below N_NODES and 2^DIAM ≥ N_NODES.
- R7: `done` is high for exactly one cycle, and that cycle immediately follows the cycle that carries the node at index DIAM.
- R8: The node at index 0 appears DIAM+2 clock cycles after the edge that accepts `start`.
- R9: A `start` pulse while a computation is running is ignored, and the running route and its stream are unchanged.
- R10: `src_node` and `dst_node` are sampled only at the accepted start. Changing them afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a route; accepted only when idle |
| src_node | input | $clog2(N_NODES) | Source switch index |
| dst_node | input | $clog2(N_NODES) | Destination switch index |
| done | output | 1 | One-cycle pulse: route finished |
| route_word | output | DIAM | Route digit word T |
| node_vld | output | 1 | A path node is presented this cycle |
| node_idx | output | $clog2(DIAM+1) | Position of the presented node along the path |
| node_out | output | $clog2(N_NODES) | Presented path node index |

## Verification
The bench builds the block with N_NODES=14 and DIAM=4. With a modulus that is not a power of two, both the conditional subtract in the doubling step and the add-back in the difference are exercised. The only point where this modulus is tight against 2^DIAM is reached through the equal-endpoint cases and the highest index, 13. Random source and destination pairs are mixed with the worked 3→10 route and the corner pairs. Some runs pulse `start` and change the inputs while busy, to show that the running route is unaffected.

// File: rtl/dbj_pkg.sv
package dbj_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DBL,
    ST_DIFF,
    ST_WALK,
    ST_FIN
  } dbj_state_e;

  // (2*x + b) mod n, valid for x < n and b in {0,1}
  function automatic int unsigned dbl_mod(input int unsigned x,
                                          input int unsigned b,
                                          input int unsigned n);
    int unsigned v;
    v = 2 * x + b;
    return (v >= n) ? v - n : v;
  endfunction

  // (a - b) mod n, valid for a < n and b < n
  function automatic int unsigned sub_mod(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned n);
    return (a >= b) ? a - b : a + n - b;
  endfunction

endpackage

// File: rtl/dbj_dbl_unit.sv
module dbj_dbl_unit #(
  parameter int unsigned N_NODES = 14,
  parameter int unsigned AW      = 4
) (
  input  logic [AW-1:0] x_i,
  input  logic          bit_i,
  output logic [AW-1:0] y_o
);
  always_comb y_o = AW'(dbj_pkg::dbl_mod(32'(x_i), 32'(bit_i), N_NODES));
endmodule

// File: rtl/dbj_sub_unit.sv
module dbj_sub_unit #(
  parameter int unsigned N_NODES = 14,
  parameter int unsigned AW      = 4
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] y_o
);
  always_comb y_o = AW'(dbj_pkg::sub_mod(32'(a_i), 32'(b_i), N_NODES));
endmodule

// File: rtl/dbj_route_gen.sv
module dbj_route_gen #(
  parameter int unsigned N_NODES = 14,
  parameter int unsigned DIAM    = 4,
  localparam int unsigned AW     = $clog2(N_NODES),
  localparam int unsigned IW     = $clog2(DIAM + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   src_node,
  input  logic [AW-1:0]   dst_node,
  output logic            done,
  output logic [DIAM-1:0] route_word,
  output logic            node_vld,
  output logic [IW-1:0]   node_idx,
  output logic [AW-1:0]   node_out
);
  import dbj_pkg::*;

  dbj_state_e      state;
  logic [IW-1:0]   cnt;
  logic [AW-1:0]   s_q, d_q, acc, cur;
  logic [DIAM-1:0] sh, route_q;
  logic            node_vld_q, done_q;
  logic [IW-1:0]   idx_q;
  logic [AW-1:0]   node_q;

  // combinational arithmetic results brought out for reading and checking
  logic [AW-1:0] acc_nxt, cur_nxt, diff;

  // named events
  logic start_acc, dbl_last, last_emit;
  assign start_acc = start && (state == ST_IDLE);
  assign dbl_last  = (state == ST_DBL)  && (cnt == IW'(DIAM - 1));
  assign last_emit = (state == ST_WALK) && (cnt == IW'(DIAM));

  dbj_dbl_unit #(.N_NODES(N_NODES), .AW(AW)) i_dbl_acc (
    .x_i(acc), .bit_i(1'b0), .y_o(acc_nxt));

  dbj_dbl_unit #(.N_NODES(N_NODES), .AW(AW)) i_dbl_walk (
    .x_i(cur), .bit_i(sh[DIAM-1]), .y_o(cur_nxt));

  dbj_sub_unit #(.N_NODES(N_NODES), .AW(AW)) i_sub (
    .a_i(d_q), .b_i(acc), .y_o(diff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      s_q        <= '0;
      d_q        <= '0;
      acc        <= '0;
      cur        <= '0;
      sh         <= '0;
      route_q    <= '0;
      node_vld_q <= 1'b0;
      done_q     <= 1'b0;
      idx_q      <= '0;
      node_q     <= '0;
    end else begin
      node_vld_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_acc) begin
          s_q   <= src_node;
          d_q   <= dst_node;
          acc   <= src_node;
          cnt   <= '0;
          state <= ST_DBL;
        end
        ST_DBL: begin
          acc <= acc_nxt;
          cnt <= cnt + IW'(1);
          if (dbl_last) state <= ST_DIFF;
        end
        ST_DIFF: begin
          route_q <= DIAM'(diff);
          sh      <= DIAM'(diff);
          cur     <= s_q;
          cnt     <= '0;
          state   <= ST_WALK;
        end
        ST_WALK: begin
          node_vld_q <= 1'b1;
          node_q     <= cur;
          idx_q      <= cnt;
          cur        <= cur_nxt;
          sh         <= sh << 1;
          cnt        <= cnt + IW'(1);
          if (last_emit) state <= ST_FIN;
        end
        ST_FIN: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign route_word = route_q;
  assign node_vld   = node_vld_q;
  assign node_idx   = idx_q;
  assign node_out   = node_q;

  // R6
  node_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_vld |-> (32'(node_out) < N_NODES));

  // R5
  last_is_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_vld && node_idx == IW'(DIAM)) |-> (node_out == d_q));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_vld && node_idx == IW'(DIAM)) |=> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_vld && node_idx != '0) |->
      ($past(node_vld) && node_idx == $past(node_idx) + IW'(1)));

  // R6
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DBL) |-> (32'(acc) < N_NODES));

endmodule

// File: tb/test_dbj_route_gen.sv
module test_dbj_route_gen;
  localparam int N     = 14;
  localparam int DIAM  = 4;
  localparam int AW    = $clog2(N);
  localparam int IW    = $clog2(DIAM + 1);
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [AW-1:0]   src = '0, dst = '0;
  logic            done, node_vld;
  logic [DIAM-1:0] route_word;
  logic [IW-1:0]   node_idx;
  logic [AW-1:0]   node_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dbj_route_gen #(.N_NODES(N), .DIAM(DIAM)) i_dbj_route_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .src_node(src), .dst_node(dst),
    .done(done), .route_word(route_word), .node_vld(node_vld),
    .node_idx(node_idx), .node_out(node_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // route word via direct modulo of the scaled source
  function automatic int exp_route(input int s, input int d);
    int x;
    x = (s * (1 << DIAM)) % N;
    return (d - x + N) % N;
  endfunction

  task automatic run(input int s, input int d, input bit disturb);
    int t, k, cyc;
    int p[DIAM+1];
    bit prev_vld;
    t = exp_route(s, d);
    p[0] = s;
    for (int i = 1; i <= DIAM; i++)
      p[i] = (2 * p[i-1] + ((t >> (DIAM - i)) & 1)) % N;
    @(negedge clk); start = 1'b1; src = AW'(s); dst = AW'(d);
    @(negedge clk); start = 1'b0;
    cyc = 0; k = 0; prev_vld = 1'b0;
    while (!done && cyc < 100) begin
      @(negedge clk); cyc++;
      start = 1'b0;
      if (disturb) begin
        src = AW'($urandom % N); dst = AW'($urandom % N);  // R10
        if (cyc == 2 || cyc == DIAM + 3) start = 1'b1;      // R9
      end
      if (node_vld) begin
        if (k == 0) chk("R8 first node latency", cyc, DIAM + 2);
        chk("R3 node index", int'(node_idx), k);
        if (k <= DIAM) chk(disturb ? "R9 R4 node value" : "R4 node value",
                           int'(node_out), p[k]);
        if (k == DIAM) chk("R5 last node is destination", int'(node_out), d);
        k++;
      end
      if (done) begin
        chk("R3 node count", k, DIAM + 1);
        chk("R7 done follows last node", int'(prev_vld), 1);
        chk(disturb ? "R10 route word" : "R2 route word", int'(route_word), t);
      end
      prev_vld = node_vld;
    end
    start = 1'b0;
    if (!done) chk("R7 done seen", 0, 1);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 done after reset", int'(done), 0);
    chk("R1 node_vld after reset", int'(node_vld), 0);
    chk("R1 route after reset", int'(route_word), 0);

    run(3, 10, 1'b0);
    chk("R2 worked example route", int'(route_word), 4);
    run(0, 0, 1'b0);
    run(13, 13, 1'b0);
    run(0, 13, 1'b0);
    run(13, 0, 1'b0);
    run(7, 7, 1'b1);
    run(3, 10, 1'b1);
    chk("R9 worked route kept", int'(route_word), 4);
    for (int r = 0; r < 40; r++)
      run(int'($urandom % N), int'($urandom % N), 1'(($urandom % 3) == 0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule